// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Configuration Unit

This block holds the interrupt message settings of a memory-mapped device. Software reaches it through a small register bus. It writes a vector index, a 64-bit message address in two halves and a 32-bit message payload into staging registers. It then issues a command word that acts on the staged values. A configure command copies the staged address and payload into one entry of a per-vector table. Other commands set or clear a global enable, mask or unmask one vector, and bind the configuration-change event or a chosen queue event to a vector.

The table contents, the per-vector mask bits, the global enable and the event-to-vector bindings are all driven out in parallel for a downstream interrupt router. That router builds the message writes. The block does not generate bus writes and does not take part in feature negotiation. A sharing-mode input is reported in the state register, and it gates the binding commands.

Top module: `msivt_top`

## Requirements
- R1: After synchronous active-low reset, the global enable is 0 and every vector is masked. Every table entry holds address 0 and payload 0, every event binding reads "no vector", and the select, address-low, address-high and payload staging registers read back 0.
- R2: The register offsets are: vector count at 0xC0 (read-only, returns NUM_VEC), state at 0xC4 (read-only), command at 0xC8 (write-only, reads 0), select at 0xD0, address low at 0xD4, address high at 0xD8 and payload at 0xDC. The last four read back the last value written to them. Writes to read-only offsets have no effect, and reads of any other offset return 0.
- R3: A read of the state register returns the global enable in bit 0, the sharing-mode input in bit 1, and 0 in bits 31:2.
- R4: A command word whose opcode field (bits 15:0) is 0x1 sets the global enable. Opcode 0x2 clears it.
- R5: Opcode 0x3 copies {address high, address low} and the staged payload into the table entry named by the select register. All other entries are left unchanged.
- R6: Opcode 0x4 sets the mask bit of the selected vector, and opcode 0x5 clears it.
- R7: When the select register holds a value of NUM_VEC or above, opcodes 0x3, 0x4 and 0x5 change nothing.
- R8: With sharing mode on, opcode 0x6 binds the configuration-change event to the selected vector. A select value of 0xFFFFFFFF unbinds it.
- R9: With sharing mode on, opcode 0x7 binds the queue event whose index is in command bits 31:16 to the selected vector. 0xFFFFFFFF unbinds it. A queue index of NUM_Q or above changes nothing.
- R10: Opcodes 0x6 and 0x7 change nothing when sharing mode is off, or when the select register holds a value of NUM_VEC or above other than 0xFFFFFFFF.
- R11: Command words whose opcode field is 0 or above 0x7 change nothing.
- R12: Read data is registered. The word for the offset presented with the read strobe appears after that clock edge, and it holds while no read is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sharing_en | input | 1 | Sharing mode: allows event binding commands |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| msi_enable | output | 1 | Global message interrupt enable |
| vec_addr | output | NUM_VEC*64 | Message address per vector, vector 0 in the low bits |
| vec_data | output | NUM_VEC*32 | Message payload per vector |
| vec_mask | output | NUM_VEC | Mask bit per vector |
| cfg_map_valid | output | 1 | Configuration event is bound |
| cfg_map_idx | output | VEC_W | Vector bound to the configuration event |
| q_map_valid | output | NUM_Q | Queue event bound, one bit per queue |
| q_map_idx | output | NUM_Q*VEC_W | Vector bound to each queue event |

## Verification
The bench builds the block with NUM_VEC=6 and NUM_Q=3. Because six is not a power of two, select values 6 and 7 still fit in the index width but fall outside the table. This exercises the out-of-range checks for configure, mask and binding. It also separates them from the all-ones "no vector" value. Three queues let a 2-bit queue index name a queue that does not exist (index 3). Random command streams, which include unknown opcodes and a toggling sharing input, are compared against a model of the table, the bindings and the register readback.

// File: rtl/msivt_pkg.sv
// Package: offsets, opcodes and constants shared by the vector config unit.
// Assumes byte offsets on an 8-bit register address.
package msivt_pkg;

    localparam logic [7:0] OFF_MAXVEC  = 8'hC0;
    localparam logic [7:0] OFF_STATE   = 8'hC4;
    localparam logic [7:0] OFF_CMD     = 8'hC8;
    localparam logic [7:0] OFF_SEL     = 8'hD0;
    localparam logic [7:0] OFF_ADDR_LO = 8'hD4;
    localparam logic [7:0] OFF_ADDR_HI = 8'hD8;
    localparam logic [7:0] OFF_DATA    = 8'hDC;

    localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_ENABLE  = 3'd1,
        OP_DISABLE = 3'd2,
        OP_CONFIG  = 3'd3,
        OP_MASK    = 3'd4,
        OP_UNMASK  = 3'd5,
        OP_MAP_CFG = 3'd6,
        OP_MAP_Q   = 3'd7
    } msi_op_e;

endpackage

// File: rtl/msivt_regs.sv
// Register front end: decodes writes into staging registers and a one-cycle
// command, owns the global enable, and returns registered read data.
// Assumes single-cycle write and read strobes; reads never stall.
module msivt_regs
    import msivt_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sharing_en,
    input  logic        reg_wr_en,
    input  logic        reg_rd_en,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        msi_enable,
    output logic [31:0] sel,
    output logic [63:0] staged_addr,
    output logic [31:0] staged_data,
    output msi_op_e     cmd_op,
    output logic [15:0] cmd_qidx
);

    logic [31:0] addr_lo_q;
    logic [31:0] addr_hi_q;
    logic [31:0] data_q;
    logic [31:0] sel_q;
    logic        en_q;
    logic [31:0] rd_mux;
    logic        cmd_wr;

    assign cmd_wr   = reg_wr_en && (reg_addr == OFF_CMD);
    assign cmd_qidx = reg_wdata[31:16];

    // Turn a command write into an opcode; unknown codes become OP_NONE.
    always_comb begin
        cmd_op = OP_NONE;
        if (cmd_wr) begin
            case (reg_wdata[15:0])
                16'h0001: cmd_op = OP_ENABLE;
                16'h0002: cmd_op = OP_DISABLE;
                16'h0003: cmd_op = OP_CONFIG;
                16'h0004: cmd_op = OP_MASK;
                16'h0005: cmd_op = OP_UNMASK;
                16'h0006: cmd_op = OP_MAP_CFG;
                16'h0007: cmd_op = OP_MAP_Q;
                default:  cmd_op = OP_NONE;
            endcase
        end
    end

    // Staging registers written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            data_q    <= '0;
            sel_q     <= '0;
        end else if (reg_wr_en) begin
            case (reg_addr)
                OFF_SEL:     sel_q     <= reg_wdata;
                OFF_ADDR_LO: addr_lo_q <= reg_wdata;
                OFF_ADDR_HI: addr_hi_q <= reg_wdata;
                OFF_DATA:    data_q    <= reg_wdata;
                default:     ;
            endcase
        end
    end

    // Global enable, set and cleared only by commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (cmd_op == OP_ENABLE) begin
            en_q <= 1'b1;
        end else if (cmd_op == OP_DISABLE) begin
            en_q <= 1'b0;
        end
    end

    // Read multiplexer over the register map.
    always_comb begin
        case (reg_addr)
            OFF_MAXVEC:  rd_mux = 32'(NUM_VEC);
            OFF_STATE:   rd_mux = {30'd0, sharing_en, en_q};
            OFF_SEL:     rd_mux = sel_q;
            OFF_ADDR_LO: rd_mux = addr_lo_q;
            OFF_ADDR_HI: rd_mux = addr_hi_q;
            OFF_DATA:    rd_mux = data_q;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data, held between read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd_en) begin
            reg_rdata <= rd_mux;
        end
    end

    assign msi_enable  = en_q;
    assign sel         = sel_q;
    assign staged_addr = {addr_hi_q, addr_lo_q};
    assign staged_data = data_q;

endmodule

// File: rtl/msivt_vec_table.sv
// Per-vector table: message address, payload and mask bit per entry.
// Assumes the select value is compared in full width, so an index of
// NUM_VEC or above never hits an entry.
module msivt_vec_table
    import msivt_pkg::*;
#(
    parameter int NUM_VEC = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  msi_op_e               cmd_op,
    input  logic [31:0]           sel,
    input  logic [63:0]           staged_addr,
    input  logic [31:0]           staged_data,
    output logic [NUM_VEC*64-1:0] vec_addr,
    output logic [NUM_VEC*32-1:0] vec_data,
    output logic [NUM_VEC-1:0]    vec_mask
);

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_entry
        logic        hit;
        logic [63:0] addr_q;
        logic [31:0] data_q;
        logic        mask_q;

        assign hit = (sel == 32'(i));

        // Commit the staged pair on configure to this entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                data_q <= '0;
            end else if (hit && cmd_op == OP_CONFIG) begin
                addr_q <= staged_addr;
                data_q <= staged_data;
            end
        end

        // Mask bit: set on reset and mask, cleared on unmask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= 1'b1;
            end else if (hit && cmd_op == OP_MASK) begin
                mask_q <= 1'b1;
            end else if (hit && cmd_op == OP_UNMASK) begin
                mask_q <= 1'b0;
            end
        end

        assign vec_addr[i*64 +: 64] = addr_q;
        assign vec_data[i*32 +: 32] = data_q;
        assign vec_mask[i]          = mask_q;
    end

endmodule

// File: rtl/msivt_event_map.sv
// Event binding table: configuration event and each queue event hold an
// optional vector index. Assumes bindings change only in sharing mode.
module msivt_event_map
    import msivt_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int NUM_Q   = 4,
    localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sharing_en,
    input  msi_op_e                cmd_op,
    input  logic [31:0]            sel,
    input  logic [15:0]            cmd_qidx,
    output logic                   cfg_map_valid,
    output logic [VEC_W-1:0]       cfg_map_idx,
    output logic [NUM_Q-1:0]       q_map_valid,
    output logic [NUM_Q*VEC_W-1:0] q_map_idx
);

    logic             sel_in_range;
    logic             sel_none;
    logic             accept;
    logic [VEC_W-1:0] new_idx;

    assign sel_in_range = (sel < 32'(NUM_VEC));
    assign sel_none     = (sel == NO_VECTOR);
    assign accept       = sharing_en && (sel_in_range || sel_none);
    assign new_idx      = sel_in_range ? sel[VEC_W-1:0] : '0;

    // Configuration event binding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_map_valid <= 1'b0;
            cfg_map_idx   <= '0;
        end else if (accept && cmd_op == OP_MAP_CFG) begin
            cfg_map_valid <= sel_in_range;
            cfg_map_idx   <= new_idx;
        end
    end

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        logic             v_q;
        logic [VEC_W-1:0] idx_q;

        // Binding for one queue event, addressed by the command's queue field.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q   <= 1'b0;
                idx_q <= '0;
            end else if (accept && cmd_op == OP_MAP_Q && cmd_qidx == 16'(q)) begin
                v_q   <= sel_in_range;
                idx_q <= new_idx;
            end
        end

        assign q_map_valid[q]              = v_q;
        assign q_map_idx[q*VEC_W +: VEC_W] = idx_q;
    end

endmodule

// File: rtl/msivt_top.sv
// Top of the vector configuration unit: register front end, vector table
// and event binding table. Assumes one register bus master.
module msivt_top
    import msivt_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int NUM_Q   = 4,
    localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sharing_en,
    input  logic                   reg_wr_en,
    input  logic                   reg_rd_en,
    input  logic [7:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    output logic                   msi_enable,
    output logic [NUM_VEC*64-1:0]  vec_addr,
    output logic [NUM_VEC*32-1:0]  vec_data,
    output logic [NUM_VEC-1:0]     vec_mask,
    output logic                   cfg_map_valid,
    output logic [VEC_W-1:0]       cfg_map_idx,
    output logic [NUM_Q-1:0]       q_map_valid,
    output logic [NUM_Q*VEC_W-1:0] q_map_idx
);

    logic [31:0] sel;
    logic [63:0] staged_addr;
    logic [31:0] staged_data;
    msi_op_e     cmd_op;
    logic [15:0] cmd_qidx;

    msivt_regs #(.NUM_VEC(NUM_VEC)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .sharing_en  (sharing_en),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .msi_enable  (msi_enable),
        .sel         (sel),
        .staged_addr (staged_addr),
        .staged_data (staged_data),
        .cmd_op      (cmd_op),
        .cmd_qidx    (cmd_qidx)
    );

    msivt_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_op      (cmd_op),
        .sel         (sel),
        .staged_addr (staged_addr),
        .staged_data (staged_data),
        .vec_addr    (vec_addr),
        .vec_data    (vec_data),
        .vec_mask    (vec_mask)
    );

    msivt_event_map #(.NUM_VEC(NUM_VEC), .NUM_Q(NUM_Q)) u_map (
        .clk           (clk),
        .rst_n         (rst_n),
        .sharing_en    (sharing_en),
        .cmd_op        (cmd_op),
        .sel           (sel),
        .cmd_qidx      (cmd_qidx),
        .cfg_map_valid (cfg_map_valid),
        .cfg_map_idx   (cfg_map_idx),
        .q_map_valid   (q_map_valid),
        .q_map_idx     (q_map_idx)
    );

endmodule

// File: rtl/msivt_checker.sv
// Checker: temporal properties on the ports of msivt_top, attached by bind.
// Assumes the synchronous active-low reset of the top.
module msivt_checker #(
    parameter int NUM_VEC = 8,
    parameter int NUM_Q   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sharing_en,
    input logic               reg_wr_en,
    input logic               reg_rd_en,
    input logic [7:0]         reg_addr,
    input logic [31:0]        reg_wdata,
    input logic [31:0]        reg_rdata,
    input logic               msi_enable,
    input logic [NUM_VEC-1:0] vec_mask,
    input logic               cfg_map_valid,
    input logic [NUM_Q-1:0]   q_map_valid
);

    logic cmd_wr;
    assign cmd_wr = reg_wr_en && (reg_addr == 8'hC8);

    // R1: the first cycle after reset shows the cleared state.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!msi_enable && (&vec_mask) && !cfg_map_valid && (q_map_valid == '0)));

    // R4: the enable opcode sets the global enable.
    p_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[15:0] == 16'h0001) |=> msi_enable);

    // R4: the disable opcode clears the global enable.
    p_disable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && reg_wdata[15:0] == 16'h0002) |=> !msi_enable);

    // R11: no other write moves the global enable.
    p_enable_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr && (reg_wdata[15:0] == 16'h0001 || reg_wdata[15:0] == 16'h0002))
        |=> $stable(msi_enable));

    // R10: bindings never change while sharing mode is off.
    p_map_needs_sharing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sharing_en |=> ($stable(cfg_map_valid) && $stable(q_map_valid)));

    // R12: read data holds without a read strobe.
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

    // R3: a state read returns enable and sharing mode, upper bits zero.
    p_state_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == 8'hC4)
        |=> (reg_rdata == {30'd0, $past(sharing_en), $past(msi_enable)}));

endmodule

bind msivt_top msivt_checker #(.NUM_VEC(NUM_VEC), .NUM_Q(NUM_Q)) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sharing_en    (sharing_en),
    .reg_wr_en     (reg_wr_en),
    .reg_rd_en     (reg_rd_en),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .msi_enable    (msi_enable),
    .vec_mask      (vec_mask),
    .cfg_map_valid (cfg_map_valid),
    .q_map_valid   (q_map_valid)
);

// File: tb/tb_msivt_top.sv
`timescale 1ns/1ps
module tb_msivt_top;

    localparam int NV = 6;
    localparam int NQ = 3;
    localparam int VW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sharing_en = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic            reg_rd_en = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic            msi_enable;
    logic [NV*64-1:0] vec_addr;
    logic [NV*32-1:0] vec_data;
    logic [NV-1:0]   vec_mask;
    logic            cfg_map_valid;
    logic [VW-1:0]   cfg_map_idx;
    logic [NQ-1:0]   q_map_valid;
    logic [NQ*VW-1:0] q_map_idx;

    msivt_top #(.NUM_VEC(NV), .NUM_Q(NQ)) dut (
        .clk(clk), .rst_n(rst_n), .sharing_en(sharing_en),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_enable(msi_enable),
        .vec_addr(vec_addr), .vec_data(vec_data), .vec_mask(vec_mask),
        .cfg_map_valid(cfg_map_valid), .cfg_map_idx(cfg_map_idx),
        .q_map_valid(q_map_valid), .q_map_idx(q_map_idx)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Model of the requirements.
    logic [63:0] m_addr [NV];
    logic [31:0] m_data [NV];
    logic        m_mask [NV];
    logic        m_en;
    logic        m_cfg_v;
    logic [VW-1:0] m_cfg_i;
    logic        m_q_v [NQ];
    logic [VW-1:0] m_q_i [NQ];
    logic [31:0] m_sel, m_lo, m_hi, m_dat;

    task automatic model_reset();
        for (int i = 0; i < NV; i++) begin
            m_addr[i] = '0; m_data[i] = '0; m_mask[i] = 1'b1;
        end
        for (int q = 0; q < NQ; q++) begin
            m_q_v[q] = 1'b0; m_q_i[q] = '0;
        end
        m_en = 0; m_cfg_v = 0; m_cfg_i = '0;
        m_sel = '0; m_lo = '0; m_hi = '0; m_dat = '0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        logic in_rng, none;
        logic [15:0] q;
        in_rng = (m_sel < NV);
        none   = (m_sel == 32'hFFFF_FFFF);
        q      = d[31:16];
        case (a)
            8'hD0: m_sel = d;
            8'hD4: m_lo  = d;
            8'hD8: m_hi  = d;
            8'hDC: m_dat = d;
            8'hC8: begin
                case (d[15:0])
                    16'd1: m_en = 1'b1;
                    16'd2: m_en = 1'b0;
                    16'd3: if (in_rng) begin
                        m_addr[m_sel] = {m_hi, m_lo}; m_data[m_sel] = m_dat;
                    end
                    16'd4: if (in_rng) m_mask[m_sel] = 1'b1;
                    16'd5: if (in_rng) m_mask[m_sel] = 1'b0;
                    16'd6: if (sharing_en && (in_rng || none)) begin
                        m_cfg_v = in_rng; m_cfg_i = in_rng ? m_sel[VW-1:0] : '0;
                    end
                    16'd7: if (sharing_en && (in_rng || none) && q < NQ) begin
                        m_q_v[q] = in_rng; m_q_i[q] = in_rng ? m_sel[VW-1:0] : '0;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'hC0: return 32'(NV);
            8'hC4: return {30'd0, sharing_en, m_en};
            8'hD0: return m_sel;
            8'hD4: return m_lo;
            8'hD8: return m_hi;
            8'hDC: return m_dat;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [NV-1:0] em;
        for (int i = 0; i < NV; i++) em[i] = m_mask[i];
        chk({tag, " enable"}, 64'(msi_enable), 64'(m_en));
        chk({tag, " mask"}, 64'(vec_mask), 64'(em));
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("%s addr[%0d]", tag, i), vec_addr[i*64 +: 64], m_addr[i]);
            chk($sformatf("%s data[%0d]", tag, i), 64'(vec_data[i*32 +: 32]), 64'(m_data[i]));
        end
        chk({tag, " cfg map"}, {cfg_map_valid, 60'd0, cfg_map_idx}, {m_cfg_v, 60'd0, m_cfg_i});
        for (int q = 0; q < NQ; q++)
            chk($sformatf("%s q map[%0d]", tag, q),
                {q_map_valid[q], 60'd0, q_map_idx[q*VW +: VW]}, {m_q_v[q], 60'd0, m_q_i[q]});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [31:0] e;
        @(negedge clk);
        e = exp_read(a);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk($sformatf("%s read %h", tag, a), 64'(reg_rdata), 64'(e));
    endtask

    task automatic set_sharing(input logic v);
        @(negedge clk);
        sharing_en = v;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports and in the staging registers.
        check_all("R1");
        rd_chk("R1", 8'hD0); rd_chk("R1", 8'hD4);
        rd_chk("R1", 8'hD8); rd_chk("R1", 8'hDC);
        rd_chk("R3", 8'hC4);

        // R2: readback, read-only offsets, unmapped offsets.
        wr(8'hD0, 32'd2); wr(8'hD4, 32'hAAAA_0004); wr(8'hD8, 32'h1234_5678); wr(8'hDC, 32'hCAFE_0002);
        rd_chk("R2", 8'hD0); rd_chk("R2", 8'hD4); rd_chk("R2", 8'hD8); rd_chk("R2", 8'hDC);
        rd_chk("R2", 8'hC0);
        wr(8'hC0, 32'h0000_1234); wr(8'hC4, 32'hFFFF_FFFF);
        rd_chk("R2", 8'hC0); rd_chk("R3", 8'hC4);
        rd_chk("R2", 8'h10); rd_chk("R2", 8'hC8); rd_chk("R2", 8'hCC);
        check_all("R2");

        // R4: enable and disable, also seen in the state register (R3).
        wr(8'hC8, 32'd1); check_all("R4 enable"); rd_chk("R3", 8'hC4);
        set_sharing(1'b1); rd_chk("R3", 8'hC4);
        wr(8'hC8, 32'd2); check_all("R4 disable");
        set_sharing(1'b0);

        // R5: configure commits only the selected entry.
        wr(8'hC8, 32'd3); check_all("R5 cfg vec2");
        wr(8'hD0, 32'd5); wr(8'hD4, 32'h0000_FEE0); wr(8'hD8, 32'd0); wr(8'hDC, 32'h41);
        wr(8'hC8, 32'd3); check_all("R5 cfg vec5");

        // R6: unmask and mask the selected vector.
        wr(8'hC8, 32'd5); check_all("R6 unmask");
        wr(8'hD0, 32'd0); wr(8'hC8, 32'd5); check_all("R6 unmask0");
        wr(8'hC8, 32'd4); check_all("R6 mask0");

        // R7: out-of-range select values change nothing.
        wr(8'hD0, 32'd6); wr(8'hC8, 32'd3); wr(8'hC8, 32'd5); check_all("R7 sel6");
        wr(8'hD0, 32'd7); wr(8'hC8, 32'd3); wr(8'hC8, 32'd5); check_all("R7 sel7");
        wr(8'hD0, 32'hFFFF_FFFF); wr(8'hC8, 32'd5); check_all("R7 selnone");

        // R8: bind and unbind the configuration event in sharing mode.
        set_sharing(1'b1);
        wr(8'hD0, 32'd3); wr(8'hC8, 32'd6); check_all("R8 bind");
        wr(8'hD0, 32'hFFFF_FFFF); wr(8'hC8, 32'd6); check_all("R8 unbind");
        wr(8'hD0, 32'd5); wr(8'hC8, 32'd6); check_all("R8 rebind");

        // R9: queue bindings, including a queue index out of range.
        wr(8'hD0, 32'd4); wr(8'hC8, 32'h0001_0007); check_all("R9 q1");
        wr(8'hD0, 32'd1); wr(8'hC8, 32'h0003_0007); check_all("R9 q3 ignored");
        wr(8'hC8, 32'h0002_0007); check_all("R9 q2");
        wr(8'hD0, 32'hFFFF_FFFF); wr(8'hC8, 32'h0001_0007); check_all("R9 q1 unbind");

        // R10: binding ignored without sharing or with out-of-range select.
        set_sharing(1'b0);
        wr(8'hD0, 32'd1); wr(8'hC8, 32'd6); wr(8'hC8, 32'h0000_0007); check_all("R10 no sharing");
        set_sharing(1'b1);
        wr(8'hD0, 32'd6); wr(8'hC8, 32'd6); wr(8'hC8, 32'h0002_0007); check_all("R10 sel6");

        // R11: unknown opcodes change nothing.
        wr(8'hD0, 32'd2);
        wr(8'hC8, 32'd0); wr(8'hC8, 32'd8); wr(8'hC8, 32'h0001_0100); wr(8'hC8, 32'hFFFF_FFFF);
        check_all("R11"); rd_chk("R11", 8'hC4);

        // R12: read data holds while no read is strobed.
        rd_chk("R12", 8'hD4);
        held = reg_rdata;
        wr(8'hD4, 32'h0BAD_F00D); wr(8'hC8, 32'd1);
        repeat (3) @(negedge clk);
        chk("R12 hold", 64'(reg_rdata), 64'(held));
        rd_chk("R12", 8'hD4);

        // Random command streams mixed with readback.
        for (int n = 0; n < 600; n++) begin
            int kind;
            kind = $urandom_range(0, 9);
            case (kind)
                0: wr(8'hD0, ($urandom_range(0, 9) == 9) ? 32'hFFFF_FFFF : 32'($urandom_range(0, 7)));
                1: wr(8'hD4, $urandom());
                2: wr(8'hD8, $urandom());
                3: wr(8'hDC, $urandom());
                4: set_sharing(1'($urandom_range(0, 1)));
                5: rd_chk("R2 random", 8'hC0 + 8'(4 * $urandom_range(0, 7)));
                default: wr(8'hC8, {16'($urandom_range(0, 3)), 16'($urandom_range(0, 9))});
            endcase
            if (kind != 5) check_all("R5/R6/R8/R9 random");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule